// File: doc/BRIEF.md
# One-Hot Addressed Register File with Optional Zero Word

This block holds a small array of data words with one read port and one write port. Neither port takes a binary address. Each takes a select vector with one bit per word, already decoded by the surrounding logic, so the block contains no address decoder. A write stores one word taken from one of two input data buses. A single bus-select bit picks which bus supplies the data, so a datapath can feed either of two sources into the array without an external multiplexer.

Reads are combinational: the output follows the word whose read-select bit is set. Writes land on the rising clock edge. A build-time flag turns word 0 into a constant-zero register. In that mode writes aimed at word 0 are dropped, and reads of word 0 always give zero. This is the usual arrangement for an architectural zero register.

Top module: `rf_onehot_top`

## Requirements
- R1: Reset is synchronous and active low. A rising clock edge with `rst_n` low clears every word to zero, and any write requested in that cycle is discarded.
- R2: `wr_sel` carries at most one set bit. With `bus_sel` = 0, a rising edge with `rst_n` high stores `wdata_a` into the word whose `wr_sel` bit is set.
- R3: With `bus_sel` = 1, the write stores `wdata_b` instead of `wdata_a`.
- R4: When `wr_sel` is all zero, no word changes, whatever values the data buses carry.
- R5: `rd_sel` carries at most one set bit. `rdata` is combinational and equals the word whose `rd_sel` bit is set (bit i selects word i).
- R6: When `rd_sel` is all zero, `rdata` is zero.
- R7: With `ZERO_REG` = 1, word 0 (`rd_sel`/`wr_sel` bit 0) always reads zero and writes to it are ignored. With `ZERO_REG` = 0, word 0 behaves like any other word.
- R8: A read of a word that is being written in the same cycle returns the old contents. The new value appears only after the clock edge.
- R9: A write changes only the selected word. All other words keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Write source: 0 selects `wdata_a`, 1 selects `wdata_b` |
| rd_sel | input | W | One-hot read select, one bit per word |
| wr_sel | input | W | One-hot write select, one bit per word |
| wdata_a | input | N | First write data bus |
| wdata_b | input | N | Second write data bus |
| rdata | output | N | Read data of the selected word |

## Verification
A read and a write can hit the same word in the same cycle. The bench provokes this by driving `rd_sel` equal to `wr_sel` with fresh bus data. It samples `rdata` a couple of nanoseconds after the inputs settle and before the rising edge, where it must still hold the old word. It samples again in the next cycle, where the new word must appear. The same collision is also aimed at word 0 on two copies of the block, one with `ZERO_REG` = 1 and one with `ZERO_REG` = 0, so the zero-word rule and the ordinary write path are judged against each other under the same stimulus.

// File: rtl/rf_pkg.sv
// Package rf_pkg
// Shared encodings for the one-hot register file.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package rf_pkg;

    // Encoding of the write-source select bit
    typedef enum logic {
        WBUS_A = 1'b0,
        WBUS_B = 1'b1
    } wbus_e;

endpackage : rf_pkg

// File: rtl/rf_wr_mux.sv
// Module rf_wr_mux
// Chooses which of the two write data buses feeds the storage array.
// Assumes: bus_sel_i is a known 0/1 value whenever a write is requested.
module rf_wr_mux
    import rf_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         bus_sel_i,
    input  logic [N-1:0] wdata_a_i,
    input  logic [N-1:0] wdata_b_i,
    output logic [N-1:0] wdata_o
);

    // Pick the write source according to the bus-select encoding
    always_comb begin
        case (wbus_e'(bus_sel_i))
            WBUS_B:  wdata_o = wdata_b_i;
            default: wdata_o = wdata_a_i;
        endcase
    end

endmodule : rf_wr_mux

// File: rtl/rf_word_bank.sv
// Module rf_word_bank
// Storage for W words of N bits, written through a one-hot select.
// Word 0 is optionally a constant zero (ZERO_REG = 1).
// Assumes: wr_sel_i has at most one bit set; reset is synchronous, active low.
module rf_word_bank #(
    parameter int N        = 32,
    parameter int W        = 8,
    parameter bit ZERO_REG = 1'b1,
    localparam int FLAT    = N * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    wr_sel_i,
    input  logic [N-1:0]    wdata_i,
    output logic [FLAT-1:0] words_o
);

    for (genvar gi = 0; gi < W; gi++) begin : g_word
        if (ZERO_REG && gi == 0) begin : g_const
            // Constant-zero word: no storage, writes have nowhere to land
            assign words_o[gi*N +: N] = '0;
        end else begin : g_store
            logic [N-1:0] word_q;

            // Clear on reset, otherwise load when this word is selected
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_sel_i[gi]) begin
                    word_q <= wdata_i;
                end
            end

            assign words_o[gi*N +: N] = word_q;
        end
    end

endmodule : rf_word_bank

// File: rtl/rf_rd_mux.sv
// Module rf_rd_mux
// AND-OR read multiplexer steered by a one-hot select.
// Assumes: rd_sel_i has at most one bit set; all-zero yields zero.
module rf_rd_mux #(
    parameter int N     = 32,
    parameter int W     = 8,
    localparam int FLAT = N * W
) (
    input  logic [W-1:0]    rd_sel_i,
    input  logic [FLAT-1:0] words_i,
    output logic [N-1:0]    rdata_o
);

    // OR together every word gated by its own select bit
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < W; i++) begin
            if (rd_sel_i[i]) begin
                rdata_o = rdata_o | words_i[i*N +: N];
            end
        end
    end

endmodule : rf_rd_mux

// File: rtl/rf_onehot_top.sv
// Module rf_onehot_top
// Register file with one-hot read and write selects, a two-bus write
// source and an optional constant-zero word 0.
// Assumes: callers drive rd_sel and wr_sel with at most one bit set;
// reads are combinational, writes land on the rising edge.
module rf_onehot_top #(
    parameter int N        = 32,
    parameter int W        = 8,
    parameter bit ZERO_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic [W-1:0] rd_sel,
    input  logic [W-1:0] wr_sel,
    input  logic [N-1:0] wdata_a,
    input  logic [N-1:0] wdata_b,
    output logic [N-1:0] rdata
);

    localparam int FLAT = N * W;

    logic [N-1:0]    wdata;
    logic [FLAT-1:0] words;

    // Source select for the write path
    rf_wr_mux #(.N(N)) u_wr_mux (
        .bus_sel_i (bus_sel),
        .wdata_a_i (wdata_a),
        .wdata_b_i (wdata_b),
        .wdata_o   (wdata)
    );

    // Word storage
    rf_word_bank #(.N(N), .W(W), .ZERO_REG(ZERO_REG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel_i (wr_sel),
        .wdata_i  (wdata),
        .words_o  (words)
    );

    // Read path
    rf_rd_mux #(.N(N), .W(W)) u_rd_mux (
        .rd_sel_i (rd_sel),
        .words_i  (words),
        .rdata_o  (rdata)
    );

endmodule : rf_onehot_top

// File: rtl/rf_onehot_checker.sv
// Module rf_onehot_checker
// Port-level properties of rf_onehot_top, bound into every instance.
// Assumes: observes only the top-level ports.
module rf_onehot_checker #(
    parameter int N        = 32,
    parameter int W        = 8,
    parameter bit ZERO_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic [W-1:0] rd_sel,
    input logic [W-1:0] wr_sel,
    input logic [N-1:0] wdata_a,
    input logic [N-1:0] wdata_b,
    input logic [N-1:0] rdata
);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rdata == '0);

    assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // Covers R2 and R3: the selected bus value is visible in the next cycle
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel != '0 && !(ZERO_REG && wr_sel[0]))
        |=> (rd_sel != $past(wr_sel) ||
             rdata == ($past(bus_sel) ? $past(wdata_b) : $past(wdata_a))));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == '0) |=> (rd_sel != $past(rd_sel) || rdata == $past(rdata)));

    assert_rd_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));

    assert_idle_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == '0) |-> rdata == '0);

    assert_zero_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_REG && rd_sel[0]) |-> rdata == '0);

endmodule : rf_onehot_checker

bind rf_onehot_top rf_onehot_checker #(.N(N), .W(W), .ZERO_REG(ZERO_REG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .rd_sel  (rd_sel),
    .wr_sel  (wr_sel),
    .wdata_a (wdata_a),
    .wdata_b (wdata_b),
    .rdata   (rdata)
);

// File: tb/tb_rf_onehot_top.sv
// Bench for rf_onehot_top: two copies (zero word on and off) share stimulus.
module tb_rf_onehot_top;

    localparam int N = 32;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic [W-1:0] rd_sel = '0;
    logic [W-1:0] wr_sel = '0;
    logic [N-1:0] wdata_a = '0;
    logic [N-1:0] wdata_b = '0;
    logic [N-1:0] rdata_z;
    logic [N-1:0] rdata_p;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    rf_onehot_top #(.N(N), .W(W), .ZERO_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .rd_sel(rd_sel),
        .wr_sel(wr_sel), .wdata_a(wdata_a), .wdata_b(wdata_b), .rdata(rdata_z)
    );

    rf_onehot_top #(.N(N), .W(W), .ZERO_REG(1'b0)) dut_plain (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .rd_sel(rd_sel),
        .wr_sel(wr_sel), .wdata_a(wdata_a), .wdata_b(wdata_b), .rdata(rdata_p)
    );

    typedef struct packed {
        logic [W-1:0] wr;
        logic [W-1:0] rd;
        logic         bs;
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] exp_z;  // expected pre-edge rdata, zero word on
        logic [N-1:0] exp_p;  // expected pre-edge rdata, zero word off
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h02, 8'h02, 1'b0, 32'h1111_0001, 32'hBBBB_0001, 32'h0,          32'h0},
        '{8'h00, 8'h02, 1'b0, 32'h0,         32'h0,         32'h1111_0001, 32'h1111_0001},
        '{8'h04, 8'h04, 1'b1, 32'hAAAA_0002, 32'h2222_0002, 32'h0,          32'h0},
        '{8'h00, 8'h04, 1'b0, 32'h0,         32'h0,         32'h2222_0002, 32'h2222_0002},
        '{8'h01, 8'h01, 1'b0, 32'hDEAD_BEEF, 32'h0,         32'h0,          32'h0},
        '{8'h00, 8'h01, 1'b0, 32'h0,         32'h0,         32'h0,          32'hDEAD_BEEF},
        '{8'h02, 8'h00, 1'b1, 32'h0,         32'hCAFE_0001, 32'h0,          32'h0},
        '{8'h00, 8'h02, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hCAFE_0001, 32'hCAFE_0001},
        '{8'h00, 8'h04, 1'b0, 32'h0,         32'h0,         32'h2222_0002, 32'h2222_0002},
        '{8'h80, 8'h02, 1'b0, 32'h7777_0007, 32'h0,         32'hCAFE_0001, 32'hCAFE_0001},
        '{8'h00, 8'h80, 1'b0, 32'h0,         32'h0,         32'h7777_0007, 32'h7777_0007},
        '{8'h00, 8'h04, 1'b0, 32'h0,         32'h0,         32'h2222_0002, 32'h2222_0002}
    };

    // Requirement named by each vector's check
    localparam string VTAG [NV] = '{
        "R8",  // same-cycle read of word 1 sees old zero
        "R2",  // bus A landed in word 1
        "R8",  // same-cycle read of word 2 sees old zero
        "R3",  // bus B landed in word 2
        "R8",  // write to word 0, pre-edge still zero
        "R7",  // word 0: zero with option, written value without
        "R6",  // empty read select returns zero
        "R4",  // idle write with busy buses, word 1 overwritten earlier
        "R4",  // word 2 untouched by the idle write
        "R9",  // write to word 7 while reading word 1
        "R2",  // top word holds bus A value
        "R9"   // word 2 unchanged by the word 7 write
    };

    task automatic check(input string tag, input string who,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: rdata=%h expected=%h", tag, who, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // Reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        rd_sel = 8'h20;
        #2;
        check("R1", "zero-on", rdata_z, '0);
        check("R1", "zero-off", rdata_p, '0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_sel  = VECS[i].wr;
            rd_sel  = VECS[i].rd;
            bus_sel = VECS[i].bs;
            wdata_a = VECS[i].a;
            wdata_b = VECS[i].b;
            #2;
            check(VTAG[i], "zero-on", rdata_z, VECS[i].exp_z);
            check(VTAG[i], "zero-off", rdata_p, VECS[i].exp_p);
        end

        // R1: reset wins over a write requested in the same cycle
        @(negedge clk);
        rst_n   = 1'b0;
        wr_sel  = 8'h08;
        bus_sel = 1'b0;
        wdata_a = 32'h1234_5678;
        @(negedge clk);
        rst_n  = 1'b1;
        wr_sel = '0;
        rd_sel = 8'h08;
        #2;
        check("R1", "zero-on", rdata_z, '0);
        check("R1", "zero-off", rdata_p, '0);
        rd_sel = 8'h02;
        #2;
        check("R1", "zero-on", rdata_z, '0);
        check("R1", "zero-off", rdata_p, '0);
        rd_sel = 8'h01;
        #2;
        check("R1", "zero-off", rdata_p, '0);

        // R2: writes work again after reset
        @(negedge clk);
        wr_sel  = 8'h08;
        wdata_a = 32'h5A5A_A5A5;
        @(negedge clk);
        wr_sel = '0;
        rd_sel = 8'h08;
        #2;
        check("R2", "zero-on", rdata_z, 32'h5A5A_A5A5);
        check("R2", "zero-off", rdata_p, 32'h5A5A_A5A5);

        // R7: bus B write to word 0 is still dropped with the option set
        @(negedge clk);
        wr_sel  = 8'h01;
        bus_sel = 1'b1;
        wdata_b = 32'h0F0F_0F0F;
        @(negedge clk);
        wr_sel = '0;
        rd_sel = 8'h01;
        #2;
        check("R7", "zero-on", rdata_z, '0);
        check("R7", "zero-off", rdata_p, 32'h0F0F_0F0F);

        @(negedge clk);
        finish_run();
    end

endmodule : tb_rf_onehot_top